// File: doc/BRIEF.md
# Multichannel DC-Blocking High-Pass Filter

This block strips offset and slow drift from four parallel streams of signed 24-bit conversion results. All four channels share a single sample strobe. Each strobe produces one filtered result per channel one clock later. The filter is first order. It subtracts the previous input from the current one, then runs the difference through a leaky integrator. The coefficient is a power of two, so each product is built from an arithmetic shift and a subtraction. No multiplier is needed.

A 4-bit cutoff code selects the corner frequency, and the corner scales with the sample rate. At code 1 and 4000 samples per second, the -3 dB point lies near 181 Hz. Code zero turns filtering off for every channel. A bypass bit per channel lets single channels pass straight through while the others keep filtering. Each channel stores its previous input and its previous output. The output is kept with 16 fractional guard bits, and the result is rounded and clamped back to 24 bits. Whenever the configuration changes, the stored history is discarded so that old integrator contents cannot cause a transient.

Top module: `dcb_filter_top`

## Requirements
- R1: After reset, `out_valid` is 0 and every lane of `out_data` is 0.
- R2: Each clock edge that samples `in_valid` high produces exactly one cycle of `out_valid` high in the next cycle. When `in_valid` is low, `out_valid` is low in the next cycle and `out_data` holds its value.
- R3: With `cutoff_code` = 0, every channel's output equals that channel's input on the same strobe.
- R4: A channel whose `ch_bypass` bit is 1 outputs its input unchanged, whatever the cutoff code.
- R5: For a channel with code c in 1..15 and bypass 0, let k = c+1 and D = (x - xp)·2^16, where xp is the previous input. The new state is y = D - floor(D/2^(k+1)) + yp - floor(yp/2^k), clamped to ±(2^41-1). The output is floor((y + 2^15)/2^16), clamped to -2^23..2^23-1.
- R6: At code 1, after a step of size S from a cleared state, the 17th output is below 1% of S in magnitude and the 88th output is 0.
- R7: At code 2, after a step of size S from a cleared state, the 36th output is below 1% of S in magnitude.
- R8: On an active channel whose input stays constant, the magnitude of the stored output never grows from one strobe to the next.
- R9: A change of `cutoff_code` clears the history of all channels. The first strobe after the change is filtered with zero previous input and zero previous output.
- R10: A toggle of a channel's `ch_bypass` bit clears that channel's history in the same way.
- R11: Channel n occupies bits [24n+23:24n] of `in_data` and `out_data` and uses bit n of `ch_bypass`. Channels do not affect each other.
- R12: A filtered result outside the 24-bit signed range is clamped to 8388607 or -8388608.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe shared by all channels |
| in_data | input | 96 | Four signed 24-bit samples, channel 0 in the low bits |
| cutoff_code | input | 4 | 0 = filter off, 1..15 = coefficient 2^-(code+1) |
| ch_bypass | input | 4 | Per-channel bypass, 1 = pass through |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 96 | Four signed 24-bit results, same packing as `in_data` |

## Verification
Each channel is driven with a step of a different sign and amplitude. This separates correct exponential decay, and the settling points at codes 1 and 2, from a wrong shift amount or a wrong fractional alignment. Pseudo-random strobes with gaps, run at codes 5, 9 and 15 with mixed bypass bits, compare every output bit-exactly with a recurrence model. These runs expose rounding direction, lane packing and leakage between channels. Separate steps between the two full-scale extremes drive the result past the 24-bit range and check the clamp. Configuration changes made in the middle of a steady input check that history is cleared, because a stale history would give a different first output.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
   // Width of the cutoff code and the largest shift it can select.
   localparam int CODE_W    = 4;
   localparam int MAX_SHIFT = (1 << CODE_W);

   // Shift width able to hold MAX_SHIFT + 1.
   function automatic int shift_bits(input int code_w);
      return $clog2((1 << code_w) + 2);
   endfunction
endpackage

// File: rtl/dcb_coef_dec.sv
module dcb_coef_dec #(
   parameter int CW  = 4,
   parameter int SHW = 5
) (
   input  logic [CW-1:0]  code,
   output logic           active,
   output logic [SHW-1:0] shift
);
   initial begin
      assert (SHW >= $clog2((1 << CW) + 2))
         else $error("dcb_coef_dec: SHW too narrow for CW");
   end

   // Coefficient a = 2^-(code+1); zero code means filter off.
   always_comb begin
      active = (code != '0);
      shift  = SHW'(code) + SHW'(1);
   end
endmodule

// File: rtl/dcb_cfg_watch.sv
module dcb_cfg_watch #(
   parameter int CW  = 4,
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [CW-1:0]  code,
   input  logic [NCH-1:0] bypass,
   output logic [NCH-1:0] clr
);
   logic [CW-1:0]  code_q;
   logic [NCH-1:0] byp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         byp_q  <= '0;
      end else begin
         code_q <= code;
         byp_q  <= bypass;
      end
   end

   // History is dropped on any cutoff change or on a per-lane bypass toggle.
   always_comb begin
      clr = {NCH{code != code_q}} | (bypass ^ byp_q);
   end
endmodule

// File: rtl/dcb_chan.sv
module dcb_chan #(
   parameter int DW    = 24,
   parameter int FW    = 16,
   parameter int SHW   = 5,
   parameter bit ROUND = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 clr,
   input  logic                 en,
   input  logic [SHW-1:0]       shift,
   input  logic signed [DW-1:0] x,
   output logic signed [DW-1:0] out_y
);
   localparam int SW = DW + FW + 2;
   localparam int EW = SW + 2;
   localparam logic signed [EW-1:0] S_MAX    = EW'((64'sd1 <<< (SW - 1)) - 64'sd1);
   localparam logic signed [EW-1:0] S_MIN    = -S_MAX;
   localparam logic signed [EW-1:0] O_MAX    = EW'((64'sd1 <<< (DW - 1)) - 64'sd1);
   localparam logic signed [EW-1:0] O_MIN    = -O_MAX - EW'(1);
   localparam logic signed [EW-1:0] RND_HALF = EW'(64'sd1 <<< (FW - 1));

   initial begin
      assert (DW >= 8 && FW >= 2) else $error("dcb_chan: DW or FW too small");
      assert (EW <= 62) else $error("dcb_chan: state wider than 62 bits");
   end

   logic signed [DW-1:0] xp_q;
   logic signed [SW-1:0] yp_q;
   logic signed [EW-1:0] x_e, xp_e, yp_e, d, fwd, fb, ysum, y_sat, o_full, o_sat;

   always_comb begin
      x_e  = EW'(x);
      xp_e = clr ? '0 : EW'(xp_q);
      yp_e = clr ? '0 : EW'(yp_q);
      d    = (x_e - xp_e) <<< FW;
      fwd  = d - (d >>> (shift + 1'b1));
      fb   = yp_e - (yp_e >>> shift);
      ysum = fwd + fb;
      if (ysum > S_MAX)      y_sat = S_MAX;
      else if (ysum < S_MIN) y_sat = S_MIN;
      else                   y_sat = ysum;
   end

   generate
      if (ROUND) begin : g_round
         assign o_full = (y_sat + RND_HALF) >>> FW;
      end else begin : g_trunc
         assign o_full = y_sat >>> FW;
      end
   endgenerate

   always_comb begin
      if (o_full > O_MAX)      o_sat = O_MAX;
      else if (o_full < O_MIN) o_sat = O_MIN;
      else                     o_sat = o_full;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xp_q  <= '0;
         yp_q  <= '0;
         out_y <= '0;
      end else if (in_valid) begin
         if (!en) begin
            xp_q  <= '0;
            yp_q  <= '0;
            out_y <= x;
         end else begin
            xp_q  <= x;
            yp_q  <= SW'(y_sat);
            out_y <= DW'(o_sat);
         end
      end else if (clr) begin
         xp_q <= '0;
         yp_q <= '0;
      end
   end

   logic [SW-1:0] ymag;
   always_comb ymag = yp_q[SW-1] ? SW'(-yp_q) : SW'(yp_q);

   // R2
   hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_y));
   // R4
   bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !en) |=> (out_y == $past(x)));
   // R9
   clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !in_valid) |=> (xp_q == '0 && yp_q == '0));
   // R8
   decay_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && en && !clr && x == xp_q) |=> (ymag <= $past(ymag)));
endmodule

// File: rtl/dcb_filter_top.sv
module dcb_filter_top #(
   parameter int NCH   = 4,
   parameter int DW    = 24,
   parameter int FW    = 16,
   parameter int CW    = dcb_pkg::CODE_W,
   parameter bit ROUND = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [NCH*DW-1:0]   in_data,
   input  logic [CW-1:0]       cutoff_code,
   input  logic [NCH-1:0]      ch_bypass,
   output logic                out_valid,
   output logic [NCH*DW-1:0]   out_data
);
   localparam int SHW = dcb_pkg::shift_bits(CW);

   initial begin
      assert (NCH >= 1) else $error("dcb_filter_top: NCH must be positive");
      assert (CW >= 1 && CW <= 5) else $error("dcb_filter_top: CW out of range");
   end

   logic           active;
   logic [SHW-1:0] shift;
   logic [NCH-1:0] clr;

   dcb_coef_dec #(.CW(CW), .SHW(SHW)) u_dec (
      .code   (cutoff_code),
      .active (active),
      .shift  (shift)
   );

   dcb_cfg_watch #(.CW(CW), .NCH(NCH)) u_watch (
      .clk    (clk),
      .rst_n  (rst_n),
      .code   (cutoff_code),
      .bypass (ch_bypass),
      .clr    (clr)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic signed [DW-1:0] y_c;
         dcb_chan #(.DW(DW), .FW(FW), .SHW(SHW), .ROUND(ROUND)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid),
            .clr      (clr[c]),
            .en       (active && !ch_bypass[c]),
            .shift    (shift),
            .x        ($signed(in_data[c*DW +: DW])),
            .out_y    (y_c)
         );
         assign out_data[c*DW +: DW] = y_c;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   // R2
   strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R2
   strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R3
   off_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cutoff_code == '0) |=> (out_data == $past(in_data)));
endmodule

// File: tb/dcb_filter_top_tb_top.sv
module dcb_filter_top_tb_top;
   localparam int NCH = 4;
   localparam int DW  = 24;
   localparam longint SMAX = (64'sd1 <<< 41) - 1;
   localparam longint OMAX = (64'sd1 <<< 23) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [NCH*DW-1:0] in_data = '0;
   logic [3:0] code = '0;
   logic [NCH-1:0] byp = '0;
   logic out_valid;
   logic [NCH*DW-1:0] out_data;

   always #4 clk = ~clk;

   dcb_filter_top dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .cutoff_code(code), .ch_bypass(byp), .out_valid(out_valid), .out_data(out_data)
   );

   int n_chk = 0, n_fail = 0;
   string cur_req = "R1";
   longint drv[NCH];
   longint m_xp[NCH], m_yp[NCH], exp_y[NCH];
   bit exp_v = 1'b0;
   int code_last = 0;
   logic [NCH-1:0] byp_last = '0;
   longint hist[NCH][256];
   int hcnt = 0;
   int unsigned seed = 32'h1234_5678;

   function automatic longint clampv(longint v, longint lo, longint hi);
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   function automatic longint absv(longint v);
      return (v < 0) ? -v : v;
   endfunction

   function automatic longint rnd24();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return longint'($signed(seed[31:8]));
   endfunction

   task automatic check(string req, bit ok, string what, longint act, longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   task automatic tick(bit v);
      @(negedge clk);
      check("R2", out_valid == exp_v, "out_valid", longint'(out_valid), longint'(exp_v));
      if (exp_v) begin
         for (int c = 0; c < NCH; c++) begin
            longint act;
            act = longint'($signed(out_data[c*DW +: DW]));
            check(cur_req, act == exp_y[c], $sformatf("lane %0d model", c), act, exp_y[c]);
            if (hcnt < 256) hist[c][hcnt] = act;
         end
         hcnt++;
      end
      in_valid = v;
      for (int c = 0; c < NCH; c++) in_data[c*DW +: DW] = drv[c][DW-1:0];
      for (int c = 0; c < NCH; c++) begin
         bit clr, en;
         clr = (int'(code) != code_last) || (byp[c] != byp_last[c]);
         en  = (code != 0) && !byp[c];
         if (clr) begin m_xp[c] = 0; m_yp[c] = 0; end
         if (v) begin
            if (!en) begin
               m_xp[c] = 0; m_yp[c] = 0; exp_y[c] = drv[c];
            end else begin
               int k;
               longint dd, fwd, fb, y;
               k   = int'(code) + 1;
               dd  = (drv[c] - m_xp[c]) <<< 16;
               fwd = dd - (dd >>> (k + 1));
               fb  = m_yp[c] - (m_yp[c] >>> k);
               y   = clampv(fwd + fb, -SMAX, SMAX);
               m_xp[c] = drv[c];
               m_yp[c] = y;
               exp_y[c] = clampv((y + 32768) >>> 16, -OMAX - 1, OMAX);
            end
         end
      end
      code_last = int'(code);
      byp_last  = byp;
      exp_v     = v;
   endtask

   task automatic set_all(longint v);
      for (int c = 0; c < NCH; c++) drv[c] = v;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 200000, 0);
      finish_run();
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin m_xp[c] = 0; m_yp[c] = 0; exp_y[c] = 0; drv[c] = 0; end
      repeat (4) tick(1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", out_valid == 1'b0, "out_valid after reset", longint'(out_valid), 0);
      check("R1", out_data == '0, "out_data after reset", longint'(out_data[23:0]), 0);

      // R3: filter off, gapped random strobes
      cur_req = "R3"; code = 4'd0; byp = '0;
      for (int i = 0; i < 16; i++) begin
         for (int c = 0; c < NCH; c++) drv[c] = rnd24();
         tick(i[0] == 1'b0);
      end
      tick(1'b0);

      // R6 R8 R5: step response at code 1
      cur_req = "R6"; code = 4'd1; hcnt = 0;
      drv[0] = 1000000; drv[1] = -2000000; drv[2] = 3000000; drv[3] = -500000;
      for (int i = 0; i < 100; i++) tick(1'b1);
      tick(1'b0);
      check("R5", hist[0][0] == 875000, "first step output", hist[0][0], 875000);
      check("R6", absv(hist[0][16]) * 100 < 1000000, "17th output below 1%", hist[0][16], 0);
      check("R6", hist[0][87] == 0, "88th output settled", hist[0][87], 0);
      for (int i = 1; i < 100; i++) begin
         check("R8", absv(hist[0][i]) <= absv(hist[0][i-1]), "ch0 monotone decay", hist[0][i], hist[0][i-1]);
         check("R8", absv(hist[1][i]) <= absv(hist[1][i-1]), "ch1 monotone decay", hist[1][i], hist[1][i-1]);
      end

      // R7: step response at code 2
      cur_req = "R7"; code = 4'd2; hcnt = 0;
      for (int i = 0; i < 40; i++) tick(1'b1);
      tick(1'b0);
      check("R7", absv(hist[0][35]) * 100 < 1000000, "36th output below 1%", hist[0][35], 0);

      // R4 R11: mixed bypass, random gapped strobes at code 5
      cur_req = "R4 R11"; code = 4'd5; byp = 4'b0101;
      for (int i = 0; i < 40; i++) begin
         for (int c = 0; c < NCH; c++) drv[c] = rnd24();
         tick(i % 3 != 2);
      end
      tick(1'b0);

      // R10: bypass toggle clears one lane
      cur_req = "R10"; code = 4'd3; byp = 4'b0010; set_all(1000000);
      for (int i = 0; i < 10; i++) tick(1'b1);
      tick(1'b0);
      byp = 4'b0000; hcnt = 0;
      for (int i = 0; i < 5; i++) tick(1'b1);
      tick(1'b0);
      check("R10", hist[1][0] == 968750, "first output after bypass toggle", hist[1][0], 968750);

      // R9: code change clears all lanes
      cur_req = "R9"; code = 4'd4; hcnt = 0;
      for (int i = 0; i < 5; i++) tick(1'b1);
      tick(1'b0);
      check("R9", hist[0][0] == 984375, "first output after code change", hist[0][0], 984375);
      check("R9", hist[3][0] == 984375, "lane 3 after code change", hist[3][0], 984375);

      // R12: full-scale jumps saturate
      cur_req = "R12"; code = 4'd1; hcnt = 0;
      drv[0] = -OMAX - 1; drv[1] = OMAX; drv[2] = 0; drv[3] = 0;
      for (int i = 0; i < 100; i++) tick(1'b1);
      drv[0] = OMAX; drv[1] = -OMAX - 1;
      for (int i = 0; i < 3; i++) tick(1'b1);
      tick(1'b0);
      check("R12", hist[0][100] == OMAX, "positive clamp", hist[0][100], OMAX);
      check("R12", hist[1][100] == -OMAX - 1, "negative clamp", hist[1][100], -OMAX - 1);

      // R5: bit-exact recurrence at long time constants
      cur_req = "R5"; code = 4'd15; byp = 4'b1000;
      for (int i = 0; i < 40; i++) begin
         for (int c = 0; c < NCH; c++) drv[c] = rnd24();
         tick(i % 4 != 3);
      end
      code = 4'd9; byp = 4'b0000;
      for (int i = 0; i < 40; i++) begin
         for (int c = 0; c < NCH; c++) drv[c] = rnd24();
         tick(1'b1);
      end
      tick(1'b0);
      tick(1'b0);
      finish_run();
   end
endmodule